// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache Controller

This block is a direct-mapped data cache holding 1024 32-bit words as 256 lines of four words. A processor presents one load or store at a time and holds it until the cache signals completion. Hits finish in the same cycle. Misses move whole lines over a memory port that carries one word per handshake. Stores that hit update only the cache and mark the line modified. A modified line is written out in full before its slot is reused.

A refill fetches the missed word first and then wraps through the rest of the line. A load is released as soon as its own word arrives. While the other words of the line are still arriving, loads to words that have already landed are served and every other request waits. A store miss reads the whole line before it merges the store, so a line never holds words from two different blocks.

Top module: `wdc_top`

## Requirements
- R1: The byte address splits as tag = bits 31:12, line index = bits 11:4, word within line = bits 3:2. Bits 1:0 are ignored, so any byte address inside a word returns that word.
- R2: After reset every line is invalid, so the first access to any line misses, and cpu_ready and mem_req are low.
- R3: A load whose index selects a valid line with a matching tag completes with cpu_ready in the cycle it is presented, returns the cached word, and causes no memory traffic.
- R4: A load miss reads all four words of the line from memory and installs them under the new tag. The line becomes valid only on the acknowledge of the fourth word.
- R5: Refill reads start at the missed word and step upward modulo four, for example words 2, 3, 0, 1 for a miss on word 2.
- R6: A load miss raises cpu_ready in the cycle the first refill word is acknowledged, with cpu_rdata equal to mem_rdata.
- R7: A store hit writes only the cache word, generates no memory traffic, and marks the line dirty. Later loads see the new value.
- R8: A miss on a dirty line first writes its four old words to memory at the old tag's addresses, in ascending word order, before any refill read. A miss on a clean line issues no writes.
- R9: A store miss completes only after all four refill words have been acknowledged. It then merges the store word and marks the line dirty. The line's other three words hold the new block's memory contents.
- R10: During a refill, after the missed load has been released, a load to a word of the refilling line that has already arrived is served at once. A load to a word that has not yet arrived, and any other request, waits until the refill ends.
- R11: Memory addresses are word aligned (bits 1:0 zero). While mem_req is high and mem_ack is low, mem_req, mem_we, mem_addr and mem_wdata hold steady. Each word completes in the cycle mem_ack is high.
- R12: cpu_ready is high only while cpu_req is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Processor byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid with cpu_ready |
| cpu_ready | output | 1 | Request completes at this clock edge |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 = write word, 0 = read word |
| mem_addr | output | 32 | Memory byte address, word aligned |
| mem_wdata | output | 32 | Write-back data |
| mem_rdata | input | 32 | Refill data, valid with mem_ack |
| mem_ack | input | 1 | Completes the current memory word |

## Verification
Assertions check the following on every cycle:
- the memory handshake holds its request steady and aligned;
- no write follows a refill read;
- refill positions advance by one modulo four;
- a load is released with the memory word on the first refill acknowledge;
- a line is installed only on the fourth acknowledge;
- stores are never released while memory is busy.

Some behaviour only the directed scenarios can show, because it depends on data and history:
- which words and addresses travel during write-back and refill;
- that stored values reach memory on eviction;
- that a store miss leaves no stale words in the line;
- that a partial-line load is served before the refill ends while a load to an unfilled word waits for it.

// File: rtl/wdc_pkg.sv
package wdc_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int BYTE_W = 2;
  localparam int WORD_W = 2;
  localparam int IDX_W  = 8;
  localparam int TAG_W  = ADDR_W - IDX_W - WORD_W - BYTE_W;
  localparam int LINES  = 1 << IDX_W;
  localparam int WORDS  = 1 << WORD_W;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;
  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {S_IDLE, S_WBACK, S_FILL, S_MERGE} ctl_st_t;

  function automatic tag_t tag_of(addr_t a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic idx_t idx_of(addr_t a);
    return a[BYTE_W+WORD_W +: IDX_W];
  endfunction

  function automatic word_t word_of(addr_t a);
    return a[BYTE_W +: WORD_W];
  endfunction

  function automatic addr_t word_addr(tag_t t, idx_t i, word_t w);
    return {t, i, w, {BYTE_W{1'b0}}};
  endfunction

  // position p of a refill that began at word s
  function automatic word_t ring_word(word_t s, word_t p);
    return word_t'(s + p);
  endfunction
endpackage

// File: rtl/wdc_data.sv
module wdc_data
  import wdc_pkg::*;
(
  input  logic  clk,
  input  logic  wr_en,
  input  idx_t  wr_idx,
  input  word_t wr_word,
  input  data_t wr_data,
  input  idx_t  rd_idx,
  input  word_t rd_word,
  output data_t rd_data
);
  localparam int DEPTH = LINES * WORDS;
  data_t store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store_q[{wr_idx, wr_word}] <= wr_data;
  end

  assign rd_data = store_q[{rd_idx, rd_word}];
endmodule

// File: rtl/wdc_tags.sv
module wdc_tags
  import wdc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  idx_t look_idx,
  output logic look_valid,
  output logic look_dirty,
  output tag_t look_tag,
  input  idx_t upd_idx,
  input  tag_t upd_tag,
  input  logic do_alloc,
  input  logic do_install,
  input  logic do_dirty
);
  logic [LINES-1:0] valid_q, dirty_q;
  tag_t tag_q [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (do_alloc) begin
        valid_q[upd_idx] <= 1'b0;
        dirty_q[upd_idx] <= 1'b0;
      end
      if (do_install) valid_q[upd_idx] <= 1'b1;
      if (do_dirty)   dirty_q[upd_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_alloc) tag_q[upd_idx] <= upd_tag;
  end

  assign look_valid = valid_q[look_idx];
  assign look_dirty = dirty_q[look_idx];
  assign look_tag   = tag_q[look_idx];
endmodule

// File: rtl/wdc_ctrl.sv
module wdc_ctrl
  import wdc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cpu_req,
  input  logic  cpu_we,
  input  addr_t cpu_addr,
  input  data_t cpu_wdata,
  output data_t cpu_rdata,
  output logic  cpu_ready,
  output logic  mem_req,
  output logic  mem_we,
  output addr_t mem_addr,
  output data_t mem_wdata,
  input  data_t mem_rdata,
  input  logic  mem_ack,
  input  logic  look_valid,
  input  logic  look_dirty,
  input  tag_t  look_tag,
  output idx_t  look_idx,
  output idx_t  upd_idx,
  output tag_t  upd_tag,
  output logic  do_alloc,
  output logic  do_install,
  output logic  do_dirty,
  output logic  d_we,
  output idx_t  d_idx,
  output word_t d_word,
  output data_t d_data,
  output idx_t  r_idx,
  output word_t r_word,
  input  data_t r_data,
  output logic  ev_miss,
  output logic  ev_fill_ack,
  output logic  ev_install,
  output word_t fill_pos,
  output word_t fill_word,
  output logic  pend_ld
);
  ctl_st_t st_q;
  word_t   cnt_q, m_word_q;
  tag_t    m_tag_q, v_tag_q;
  idx_t    m_idx_q;
  logic    m_we_q, pend_q;
  data_t   m_wdata_q;
  logic [WORDS-1:0] filled_q;

  tag_t  c_tag;
  idx_t  c_idx;
  word_t c_word;
  logic  hit, part_hit, last;

  assign c_tag  = tag_of(cpu_addr);
  assign c_idx  = idx_of(cpu_addr);
  assign c_word = word_of(cpu_addr);
  assign hit    = look_valid && (look_tag == c_tag);
  assign last   = (cnt_q == word_t'(WORDS-1));

  assign fill_pos    = cnt_q;
  assign fill_word   = ring_word(m_word_q, cnt_q);
  assign ev_fill_ack = (st_q == S_FILL) && mem_ack;
  assign ev_install  = ev_fill_ack && last;
  assign ev_miss     = (st_q == S_IDLE) && cpu_req && !hit;
  assign pend_ld     = pend_q && !m_we_q;

  assign part_hit = (st_q == S_FILL) && !pend_q && cpu_req && !cpu_we &&
                    (c_idx == m_idx_q) && (c_tag == m_tag_q) && filled_q[c_word];

  assign look_idx = c_idx;
  assign r_idx    = (st_q == S_WBACK) ? m_idx_q : c_idx;
  assign r_word   = (st_q == S_WBACK) ? cnt_q   : c_word;
  assign cpu_rdata = (ev_fill_ack && pend_q) ? mem_rdata : r_data;

  always_comb begin
    cpu_ready = 1'b0;
    mem_req = 1'b0; mem_we = 1'b0; mem_addr = '0; mem_wdata = '0;
    upd_idx = c_idx; upd_tag = c_tag;
    do_alloc = 1'b0; do_install = 1'b0; do_dirty = 1'b0;
    d_we = 1'b0; d_idx = c_idx; d_word = c_word; d_data = cpu_wdata;
    unique case (st_q)
      S_IDLE: begin
        if (cpu_req && hit) begin
          cpu_ready = 1'b1;
          d_we      = cpu_we;
          do_dirty  = cpu_we;
        end
        do_alloc = ev_miss;
      end
      S_WBACK: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = word_addr(v_tag_q, m_idx_q, cnt_q);
        mem_wdata = r_data;
      end
      S_FILL: begin
        mem_req    = 1'b1;
        mem_addr   = word_addr(m_tag_q, m_idx_q, fill_word);
        d_we       = mem_ack;
        d_idx      = m_idx_q;
        d_word     = fill_word;
        d_data     = mem_rdata;
        upd_idx    = m_idx_q;
        do_install = ev_install;
        cpu_ready  = (ev_fill_ack && cnt_q == '0 && pend_ld) || part_hit;
      end
      S_MERGE: begin
        cpu_ready = 1'b1;
        d_we      = 1'b1;
        d_idx     = m_idx_q;
        d_word    = m_word_q;
        d_data    = m_wdata_q;
        upd_idx   = m_idx_q;
        do_dirty  = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; cnt_q <= '0; m_word_q <= '0; m_tag_q <= '0; v_tag_q <= '0;
      m_idx_q <= '0; m_we_q <= 1'b0; pend_q <= 1'b0; m_wdata_q <= '0; filled_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (ev_miss) begin
          m_tag_q   <= c_tag;
          m_idx_q   <= c_idx;
          m_word_q  <= c_word;
          m_we_q    <= cpu_we;
          m_wdata_q <= cpu_wdata;
          v_tag_q   <= look_tag;
          pend_q    <= 1'b1;
          filled_q  <= '0;
          cnt_q     <= '0;
          st_q      <= (look_valid && look_dirty) ? S_WBACK : S_FILL;
        end
        S_WBACK: if (mem_ack) begin
          cnt_q <= cnt_q + 1'b1;
          if (last) st_q <= S_FILL;
        end
        S_FILL: if (mem_ack) begin
          filled_q[fill_word] <= 1'b1;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == '0 && !m_we_q) pend_q <= 1'b0;
          if (last) st_q <= m_we_q ? S_MERGE : S_IDLE;
        end
        S_MERGE: begin
          pend_q <= 1'b0;
          st_q   <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wdc_top.sv
module wdc_top
  import wdc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_req,
  input  logic        cpu_we,
  input  logic [31:0] cpu_addr,
  input  logic [31:0] cpu_wdata,
  output logic [31:0] cpu_rdata,
  output logic        cpu_ready,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack
);
  logic  look_valid, look_dirty, do_alloc, do_install, do_dirty, d_we;
  tag_t  look_tag, upd_tag;
  idx_t  look_idx, upd_idx, d_idx, r_idx;
  word_t d_word, r_word;
  data_t d_data, r_data;

  // named internal events, observed by the bound checker
  logic  ev_miss, ev_fill_ack, ev_install, pend_ld;
  word_t fill_pos, fill_word;

  wdc_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .look_valid(look_valid), .look_dirty(look_dirty), .look_tag(look_tag), .look_idx(look_idx),
    .upd_idx(upd_idx), .upd_tag(upd_tag),
    .do_alloc(do_alloc), .do_install(do_install), .do_dirty(do_dirty),
    .d_we(d_we), .d_idx(d_idx), .d_word(d_word), .d_data(d_data),
    .r_idx(r_idx), .r_word(r_word), .r_data(r_data),
    .ev_miss(ev_miss), .ev_fill_ack(ev_fill_ack), .ev_install(ev_install),
    .fill_pos(fill_pos), .fill_word(fill_word), .pend_ld(pend_ld)
  );

  wdc_tags tags_i (
    .clk(clk), .rst_n(rst_n),
    .look_idx(look_idx), .look_valid(look_valid), .look_dirty(look_dirty), .look_tag(look_tag),
    .upd_idx(upd_idx), .upd_tag(upd_tag),
    .do_alloc(do_alloc), .do_install(do_install), .do_dirty(do_dirty)
  );

  wdc_data data_i (
    .clk(clk),
    .wr_en(d_we), .wr_idx(d_idx), .wr_word(d_word), .wr_data(d_data),
    .rd_idx(r_idx), .rd_word(r_word), .rd_data(r_data)
  );
endmodule

// File: rtl/wdc_chk.sv
module wdc_chk
  import wdc_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_req,
  input logic        cpu_we,
  input logic        cpu_ready,
  input logic [31:0] cpu_rdata,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic [31:0] mem_rdata,
  input logic        mem_ack,
  input logic        ev_miss,
  input logic        ev_fill_ack,
  input logic        ev_install,
  input word_t       fill_pos,
  input word_t       fill_word,
  input logic        pend_ld
);
  word_t prev_fw;
  word_t acks_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_fw   <= '0;
      acks_seen <= '0;
    end else begin
      if (ev_fill_ack) prev_fw <= fill_word;
      if (ev_miss) acks_seen <= '0;
      else if (ev_fill_ack) acks_seen <= acks_seen + 1'b1;
    end
  end

  a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));

  a_r11_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);

  a_r12_ready_req: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_req);

  a_r8_no_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |=> !(mem_req && mem_we));

  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill_ack && fill_pos != '0 |-> fill_word == word_t'(prev_fw + 1'b1));

  a_r6_early_restart: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill_ack && fill_pos == '0 && pend_ld |-> cpu_ready && cpu_rdata == mem_rdata);

  a_r4_install_last: assert property (@(posedge clk) disable iff (!rst_n)
    ev_install |-> ev_fill_ack && acks_seen == word_t'(WORDS-1));

  a_r9_store_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && cpu_we |-> !mem_req);
endmodule

bind wdc_top wdc_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_ready(cpu_ready),
  .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
  .ev_miss(ev_miss), .ev_fill_ack(ev_fill_ack), .ev_install(ev_install),
  .fill_pos(fill_pos), .fill_word(fill_word), .pend_ld(pend_ld)
);

// File: tb/wdc_tb_top.sv
module wdc_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic cpu_ready;
  logic mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic mem_ack = 1'b0;

  always #2.5 clk = ~clk;

  wdc_top dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  int n_chk = 0, n_fail = 0;
  int acks = 0, lat_cfg = 1, log_n = 0;
  logic [31:0] log_addr [64];
  logic        log_we   [64];
  logic [31:0] log_wd   [64];
  logic [31:0] backing [logic [31:0]];
  logic [31:0] gold    [logic [31:0]];

  function automatic logic [31:0] seed_val(logic [31:0] a);
    return {a[15:0], 16'h0000} ^ a ^ 32'h5A5A_0F0F;
  endfunction
  function automatic logic [31:0] mem_val(logic [31:0] a);
    return backing.exists(a) ? backing[a] : seed_val(a);
  endfunction
  function automatic logic [31:0] gold_val(logic [31:0] a);
    logic [31:0] w = {a[31:2], 2'b00};
    return gold.exists(w) ? gold[w] : seed_val(w);
  endfunction
  function automatic logic [31:0] mk(int t, int i, int w);
    return {t[19:0], i[7:0], w[1:0], 2'b00};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // memory responder with variable latency
  initial begin
    int wait_c = 0;
    forever begin
      @(negedge clk);
      if (!rst_n || mem_ack) begin
        mem_ack = 1'b0;
        wait_c = 0;
      end else if (mem_req) begin
        if (wait_c >= lat_cfg + (acks % 2)) begin
          mem_ack = 1'b1;
          if (mem_we) backing[mem_addr] = mem_wdata;
          else mem_rdata = mem_val(mem_addr);
          if (log_n < 64) begin
            log_addr[log_n] = mem_addr; log_we[log_n] = mem_we; log_wd[log_n] = mem_wdata;
            log_n++;
          end
          acks++;
        end else wait_c++;
      end
    end
  end

  task automatic acc(input logic we, input logic [31:0] a, input logic [31:0] wd,
                     output logic [31:0] rd, output int at);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    #1;
    while (!cpu_ready) begin @(negedge clk); #1; end
    rd = cpu_rdata;
    at = acks;
    @(posedge clk); #1;
    cpu_req = 1'b0; cpu_we = 1'b0;
    if (we) gold[{a[31:2], 2'b00}] = wd;
  endtask

  task automatic clr_log();
    log_n = 0; acks = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(cpu_ready == 1'b0, "R2 ready low after reset", {31'b0, cpu_ready}, 32'h0);
    chk(mem_req == 1'b0, "R2 mem_req low after reset", {31'b0, mem_req}, 32'h0);
  endtask

  task automatic t_cold_load();
    logic [31:0] rd; int at;
    clr_log();
    acc(1'b0, mk(1, 5, 2), '0, rd, at);
    chk(rd == gold_val(mk(1, 5, 2)), "R4 cold load data", rd, gold_val(mk(1, 5, 2)));
    chk(at == 1, "R6 early restart on first ack", at, 1);
    repeat (12) @(negedge clk);
    chk(log_n == 4, "R2 cold miss reads one line", log_n, 4);
    for (int k = 0; k < 4; k++)
      chk(!log_we[k] && log_addr[k] == mk(1, 5, (2 + k) % 4), "R5 refill order",
          log_addr[k], mk(1, 5, (2 + k) % 4));
  endtask

  task automatic t_hits();
    logic [31:0] rd; int at;
    clr_log();
    acc(1'b0, mk(1, 5, 0), '0, rd, at);
    chk(rd == gold_val(mk(1, 5, 0)), "R3 hit data", rd, gold_val(mk(1, 5, 0)));
    acc(1'b0, mk(1, 5, 1) | 32'h3, '0, rd, at);
    chk(rd == gold_val(mk(1, 5, 1)), "R1 byte offset ignored", rd, gold_val(mk(1, 5, 1)));
    chk(log_n == 0, "R3 hits cause no memory traffic", log_n, 0);
  endtask

  task automatic t_store_hit();
    logic [31:0] rd; int at;
    clr_log();
    acc(1'b1, mk(1, 5, 3), 32'hDEAD_0003, rd, at);
    acc(1'b0, mk(1, 5, 3), '0, rd, at);
    chk(rd == 32'hDEAD_0003, "R7 store hit visible", rd, 32'hDEAD_0003);
    chk(log_n == 0, "R7 store hit no traffic", log_n, 0);
    chk(mem_val(mk(1, 5, 3)) == seed_val(mk(1, 5, 3)), "R7 memory untouched",
        mem_val(mk(1, 5, 3)), seed_val(mk(1, 5, 3)));
    @(negedge clk); #1;
    chk(!cpu_ready, "R12 ready low without request", {31'b0, cpu_ready}, 0);
  endtask

  task automatic t_dirty_evict();
    logic [31:0] rd; int at;
    clr_log();
    acc(1'b0, mk(2, 5, 1), '0, rd, at);
    chk(rd == gold_val(mk(2, 5, 1)), "R8 load after eviction", rd, gold_val(mk(2, 5, 1)));
    chk(at == 5, "R6 release after write-back plus first read", at, 5);
    repeat (12) @(negedge clk);
    chk(log_n == 8, "R8 write-back plus refill count", log_n, 8);
    for (int k = 0; k < 4; k++) begin
      chk(log_we[k] && log_addr[k] == mk(1, 5, k), "R8 R11 write-back address order",
          log_addr[k], mk(1, 5, k));
      chk(log_wd[k] == gold_val(mk(1, 5, k)), "R8 write-back data", log_wd[k], gold_val(mk(1, 5, k)));
      chk(!log_we[k+4] && log_addr[k+4] == mk(2, 5, (1 + k) % 4), "R5 refill after write-back",
          log_addr[k+4], mk(2, 5, (1 + k) % 4));
    end
  endtask

  task automatic t_clean_evict();
    logic [31:0] rd; int at;
    clr_log();
    acc(1'b0, mk(3, 5, 0), '0, rd, at);
    repeat (12) @(negedge clk);
    chk(log_n == 4 && !log_we[0] && !log_we[3], "R8 clean victim no writes", log_n, 4);
    chk(rd == gold_val(mk(3, 5, 0)), "R4 data after clean eviction", rd, gold_val(mk(3, 5, 0)));
  endtask

  task automatic t_store_miss();
    logic [31:0] rd; int at;
    clr_log();
    acc(1'b1, mk(4, 9, 1), 32'hC0DE_0001, rd, at);
    chk(at == 4, "R9 store released after full refill", at, 4);
    chk(log_n == 4 && log_addr[0] == mk(4, 9, 1), "R9 refill starts at store word", log_addr[0], mk(4, 9, 1));
    acc(1'b0, mk(4, 9, 1), '0, rd, at);
    chk(rd == 32'hC0DE_0001, "R9 merged word", rd, 32'hC0DE_0001);
    acc(1'b0, mk(4, 9, 2), '0, rd, at);
    chk(rd == seed_val(mk(4, 9, 2)), "R9 other words from new block", rd, seed_val(mk(4, 9, 2)));
    clr_log();
    acc(1'b0, mk(5, 9, 0), '0, rd, at);
    repeat (12) @(negedge clk);
    chk(log_n == 8 && log_we[1] && log_wd[1] == 32'hC0DE_0001, "R9 store miss line is dirty",
        log_wd[1], 32'hC0DE_0001);
    chk(log_wd[3] == seed_val(mk(4, 9, 3)), "R9 no stale word written back", log_wd[3], seed_val(mk(4, 9, 3)));
  endtask

  task automatic t_partial();
    logic [31:0] rd; int at;
    lat_cfg = 3;
    clr_log();
    acc(1'b0, mk(6, 20, 0), '0, rd, at);
    chk(at == 1, "R6 early restart slow memory", at, 1);
    acc(1'b0, mk(6, 20, 0), '0, rd, at);
    chk(at < 4, "R10 filled word served during refill", at, 3);
    chk(rd == gold_val(mk(6, 20, 0)), "R10 filled word data", rd, gold_val(mk(6, 20, 0)));
    acc(1'b0, mk(6, 20, 3), '0, rd, at);
    chk(at == 4, "R10 unfilled word waits for refill end", at, 4);
    chk(rd == gold_val(mk(6, 20, 3)), "R10 late word data", rd, gold_val(mk(6, 20, 3)));
    lat_cfg = 1;
  endtask

  task automatic t_sweep();
    logic [31:0] rd; int at;
    for (int i = 0; i < 6; i++)
      acc(1'b1, mk(7 + i, 40 + 3 * i, i % 4), 32'hAB00_0000 + i, rd, at);
    for (int i = 0; i < 6; i++) begin
      acc(1'b0, mk(7 + i, 40 + 3 * i, i % 4), '0, rd, at);
      chk(rd == 32'hAB00_0000 + i, "R7 R9 sweep readback", rd, 32'hAB00_0000 + i);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cold_load();
    t_hits();
    t_store_hit();
    t_dirty_evict();
    t_clean_evict();
    t_store_miss();
    t_partial();
    t_sweep();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule